// File: doc/BRIEF.md
# Prioritized External Interrupt Controller

This block watches six external interrupt pins and turns pin activity into prioritized interrupt requests for a processor. Every pin has its own 8-bit control register on a simple register bus. The register holds a 3-bit priority, a request flag, a polarity select and an edge/level select. A separate per-pin input chooses detection on both edges. Each pin passes through a synchronizer. When the selected condition appears, the channel's request flag becomes set and stays set until it is cleared.

On every cycle an arbiter compares the pending channels against the processor's current priority level, which is an input. Only a channel whose priority is strictly above that level may win. Among the eligible channels the highest priority wins, and on a tie the lowest-numbered channel wins. The winner is presented combinationally with its channel number and priority. When the processor pulses the acknowledge while a winner is presented, that channel's flag clears. Software may clear a flag by writing the register, but it can never set one.

Top module: `xint_prio_ctrl`

## Requirements
- R1: Synchronous active-high reset clears every channel register to 0x00 (priority 0, flag 0, polarity 0, edge mode), and `irq_valid` is 0 after reset.
- R2: Register layout: bits [2:0] priority, bit 3 request flag, bit 4 polarity (1 = rising/high, 0 = falling/low), bit 5 sensing (1 = level, 0 = edge). Bits [7:6] read 0 and ignore writes. Priority, polarity and sensing read back as written.
- R3: A write with bit 3 = 0 clears the flag, and a write with bit 3 = 1 leaves it unchanged. Addresses 6 and 7 hold no register: writes to them change nothing and reads return 0x00.
- R4: In edge mode a change of the pin in the selected direction sets the flag at the third rising clock edge after the change. A change in the other direction does not set it.
- R5: With edge sensing and the channel's both-edges input at 1, either a rising or a falling pin change sets the flag.
- R6: In level mode the flag is set while the synchronized pin is at the active level. If it is cleared while that level persists, it is set again on the following clock edge.
- R7: A channel is presented only when its flag is 1 and its priority is strictly greater than `cpu_level`. A priority-0 channel is never presented.
- R8: Among the eligible channels the one with the highest priority is presented on `irq_chan`/`irq_level`. Ties go to the lowest channel number.
- R9: `irq_ack` high while `irq_valid` is 1 clears the presented channel's flag at that clock edge. `irq_ack` has no effect while `irq_valid` is 0.
- R10: In edge mode the flag stays set after the pin returns to its idle level, until it is acknowledged or cleared by software.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register select (channel number) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the register selected by `bus_addr` (combinational) |
| pin_in | input | 6 | Asynchronous external interrupt pins |
| both_edge | input | 6 | Per-channel both-edges select |
| cpu_level | input | 3 | Current processor priority level |
| irq_valid | output | 1 | An eligible request is presented |
| irq_chan | output | 3 | Presented channel number |
| irq_level | output | 3 | Presented channel's priority |
| irq_ack | input | 1 | Acknowledge of the presented request |

## Verification
A flag that is wrongly set or cleared reaches the ports in the same cycle. It changes `irq_valid` and `irq_chan` at once, and a bus read of that channel shows it at once. A wrong synchronizer depth or a wrong edge history shifts the flag's set edge away from the third clock edge, and the per-cycle comparison against the reference model catches that. An arbitration fault with ties or strict comparison shows in the first cycle in which two channels compete or the priority equals `cpu_level`. A lost or misdirected acknowledge leaves the wrong flag standing, and the next presented channel shows it one cycle later.

// File: rtl/xint_pkg.sv
package xint_pkg;

    localparam int NUM_CH   = 6;
    localparam int CH_W     = $clog2(NUM_CH);
    localparam int LVL_W    = 3;
    localparam int REG_W    = 8;

    localparam int FLAG_BIT = 3;
    localparam int POL_BIT  = 4;
    localparam int MODE_BIT = 5;

    typedef enum logic [2:0] {
        TRIG_FALL,
        TRIG_RISE,
        TRIG_BOTH,
        TRIG_LOW,
        TRIG_HIGH
    } trig_mode_e;

    typedef struct packed {
        logic             lvs;
        logic             pol;
        logic             flag;
        logic [LVL_W-1:0] lvl;
    } chan_cfg_t;

    typedef struct packed {
        logic             valid;
        logic [CH_W-1:0]  chan;
        logic [LVL_W-1:0] lvl;
    } grant_t;

    function automatic trig_mode_e decode_mode(logic lvs, logic pol, logic both);
        trig_mode_e m;
        if (lvs)       m = pol ? TRIG_HIGH : TRIG_LOW;
        else if (both) m = TRIG_BOTH;
        else           m = pol ? TRIG_RISE : TRIG_FALL;
        return m;
    endfunction

    function automatic logic [REG_W-1:0] pack_reg(chan_cfg_t c);
        return REG_W'(c);
    endfunction

endpackage

// File: rtl/xint_pin_detect.sv
module xint_pin_detect
    import xint_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    input  logic lvs,
    input  logic pol,
    input  logic both,
    output logic trig
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   sample;
    trig_mode_e             mode;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
            prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign sample = sync_q[SYNC_STAGES-1];
    assign mode   = decode_mode(lvs, pol, both);

    always_comb begin
        unique case (mode)
            TRIG_RISE: trig = sample & ~prev_q;
            TRIG_FALL: trig = ~sample & prev_q;
            TRIG_BOTH: trig = sample ^ prev_q;
            TRIG_HIGH: trig = sample;
            TRIG_LOW:  trig = ~sample;
            default:   trig = 1'b0;
        endcase
    end

endmodule

// File: rtl/xint_chan_reg.sv
module xint_chan_reg
    import xint_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    input  logic             trig,
    input  logic             ack_clr,
    output chan_cfg_t        cfg
);

    chan_cfg_t cfg_q;
    logic      clr;
    logic      set_ok;
    logic      unused_hi;

    assign unused_hi = ^wdata[REG_W-1:MODE_BIT+1];

    // clear wins against a level trigger; an edge event is never lost
    assign clr    = ack_clr | (wr_en & ~wdata[FLAG_BIT]);
    assign set_ok = cfg_q.lvs ? (trig & ~clr) : trig;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else begin
            cfg_q.flag <= (cfg_q.flag & ~clr) | set_ok;
            if (wr_en) begin
                cfg_q.lvl <= wdata[LVL_W-1:0];
                cfg_q.pol <= wdata[POL_BIT];
                cfg_q.lvs <= wdata[MODE_BIT];
            end
        end
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/xint_arbiter.sv
module xint_arbiter
    import xint_pkg::*;
(
    input  logic [NUM_CH-1:0] pend,
    input  logic [LVL_W-1:0]  lvls [NUM_CH],
    input  logic [LVL_W-1:0]  cpu_level,
    output grant_t            grant
);

    always_comb begin
        grant = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (pend[i] && (lvls[i] > cpu_level) &&
                (!grant.valid || (lvls[i] > grant.lvl))) begin
                grant.valid = 1'b1;
                grant.chan  = CH_W'(i);
                grant.lvl   = lvls[i];
            end
        end
    end

endmodule

// File: rtl/xint_prio_ctrl.sv
module xint_prio_ctrl
    import xint_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic [NUM_CH-1:0] pin_in,
    input  logic [NUM_CH-1:0] both_edge,
    input  logic [LVL_W-1:0]  cpu_level,
    output logic              irq_valid,
    output logic [CH_W-1:0]   irq_chan,
    output logic [LVL_W-1:0]  irq_level,
    input  logic              irq_ack
);

    chan_cfg_t         cfg      [NUM_CH];
    logic [LVL_W-1:0]  lvls     [NUM_CH];
    logic [NUM_CH-1:0] flag_vec;
    logic [NUM_CH-1:0] trig_vec;
    logic [NUM_CH-1:0] wr_vec;
    logic [NUM_CH-1:0] ack_vec;
    grant_t            grant;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign wr_vec[c]  = bus_wr && (bus_addr == ADDR_W'(c));
        assign ack_vec[c] = irq_ack && grant.valid && (grant.chan == CH_W'(c));

        xint_pin_detect #(.SYNC_STAGES(SYNC_STAGES)) u_det (
            .clk  (clk),
            .rst  (rst),
            .pin  (pin_in[c]),
            .lvs  (cfg[c].lvs),
            .pol  (cfg[c].pol),
            .both (both_edge[c]),
            .trig (trig_vec[c])
        );

        xint_chan_reg u_reg (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (wr_vec[c]),
            .wdata   (bus_wdata),
            .trig    (trig_vec[c]),
            .ack_clr (ack_vec[c]),
            .cfg     (cfg[c])
        );

        assign flag_vec[c] = cfg[c].flag;
        assign lvls[c]     = cfg[c].lvl;
    end

    xint_arbiter u_arb (
        .pend      (flag_vec),
        .lvls      (lvls),
        .cpu_level (cpu_level),
        .grant     (grant)
    );

    assign irq_valid = grant.valid;
    assign irq_chan  = grant.chan;
    assign irq_level = grant.lvl;

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (bus_addr == ADDR_W'(i)) bus_rdata = pack_reg(cfg[i]);
        end
    end

endmodule

// File: rtl/xint_prio_ctrl_chk.sv
module xint_prio_ctrl_chk
    import xint_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [REG_W-1:0]  bus_wdata,
    input logic [REG_W-1:0]  bus_rdata,
    input logic [LVL_W-1:0]  cpu_level,
    input logic              irq_valid,
    input logic [CH_W-1:0]   irq_chan,
    input logic [LVL_W-1:0]  irq_level,
    input logic              irq_ack,
    input logic [NUM_CH-1:0] flag_vec,
    input logic [NUM_CH-1:0] trig_vec
);

    assert_reset_idle_R1: assert property (@(posedge clk) rst |=> !irq_valid);

    assert_pad_zero_R2: assert property (@(posedge clk) disable iff (rst)
        bus_rdata[REG_W-1:MODE_BIT+1] == '0);

    assert_sw_no_set_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && (bus_addr < ADDR_W'(NUM_CH)) && bus_wdata[FLAG_BIT] &&
         !flag_vec[bus_addr[CH_W-1:0]] && !trig_vec[bus_addr[CH_W-1:0]])
        |=> !flag_vec[$past(bus_addr[CH_W-1:0])]);

    assert_strict_level_R7: assert property (@(posedge clk) disable iff (rst)
        irq_valid |-> (irq_level > cpu_level));

    assert_grant_pending_R7: assert property (@(posedge clk) disable iff (rst)
        irq_valid |-> flag_vec[irq_chan]);

    assert_grant_range_R8: assert property (@(posedge clk) disable iff (rst)
        irq_valid |-> (irq_chan < CH_W'(NUM_CH)));

    assert_ack_clears_R9: assert property (@(posedge clk) disable iff (rst)
        (irq_valid && irq_ack && !trig_vec[irq_chan])
        |=> !flag_vec[$past(irq_chan)]);

endmodule

bind xint_prio_ctrl xint_prio_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cpu_level (cpu_level),
    .irq_valid (irq_valid),
    .irq_chan  (irq_chan),
    .irq_level (irq_level),
    .irq_ack   (irq_ack),
    .flag_vec  (flag_vec),
    .trig_vec  (trig_vec)
);

// File: tb/xint_prio_ctrl_tb.sv
`timescale 1ns/1ps
module xint_prio_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [5:0] pin_in = '0;
    logic [5:0] both_edge = '0;
    logic [2:0] cpu_level = '0;
    logic       irq_valid;
    logic [2:0] irq_chan;
    logic [2:0] irq_level;
    logic       irq_ack = 1'b0;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #10 clk = ~clk;

    xint_prio_ctrl u_dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .both_edge(both_edge), .cpu_level(cpu_level), .irq_valid(irq_valid),
        .irq_chan(irq_chan), .irq_level(irq_level), .irq_ack(irq_ack)
    );

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", req, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit m_s1[6], m_s2[6], m_prev[6], m_flag[6], m_pol[6], m_lvs[6];
    int m_lvl[6];

    function automatic int m_winner();
        int best = -1;
        for (int c = 0; c < 6; c++)
            if (m_flag[c] && m_lvl[c] > int'(cpu_level) && (best < 0 || m_lvl[c] > m_lvl[best]))
                best = c;
        return best;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < 6; c++) begin
                m_s1[c] = 0; m_s2[c] = 0; m_prev[c] = 0;
                m_flag[c] = 0; m_pol[c] = 0; m_lvs[c] = 0; m_lvl[c] = 0;
            end
        end else begin
            int w;
            bit trig, clr, wr;
            w = m_winner();
            for (int c = 0; c < 6; c++) begin
                if (m_lvs[c])          trig = (m_s2[c] == m_pol[c]);
                else if (both_edge[c]) trig = (m_s2[c] != m_prev[c]);
                else if (m_pol[c])     trig = m_s2[c] && !m_prev[c];
                else                   trig = !m_s2[c] && m_prev[c];
                wr  = bus_wr && (int'(bus_addr) == c);
                clr = (irq_ack && w == c) || (wr && !bus_wdata[3]);
                m_flag[c] = (m_flag[c] && !clr) || (trig && !(m_lvs[c] && clr));
                if (wr) begin
                    m_lvl[c] = int'(bus_wdata[2:0]);
                    m_pol[c] = bus_wdata[4];
                    m_lvs[c] = bus_wdata[5];
                end
                m_prev[c] = m_s2[c]; m_s2[c] = m_s1[c]; m_s1[c] = pin_in[c];
            end
        end
    end

    // per-cycle comparison, away from both edges and from stimulus changes
    always @(negedge clk) begin
        #5;
        if (!rst && !done) begin
            int w;
            w = m_winner();
            chk(irq_valid == (w >= 0), "R7 valid vs model", irq_valid, w >= 0);
            if (w >= 0) begin
                chk(int'(irq_chan) == w, "R8 chan vs model", irq_chan, w);
                chk(int'(irq_level) == m_lvl[w], "R8 level vs model", irq_level, m_lvl[w]);
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(int a, logic [7:0] d);
        bus_wr = 1'b1; bus_addr = 3'(a); bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(int a, int exp, string req);
        bus_addr = 3'(a);
        #1;
        chk(bus_rdata == 8'(exp), req, bus_rdata, exp);
    endtask

    task automatic ack_once();
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        chk(0, "watchdog", 0, 1);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        cyc(3);
        rst = 1'b0;
        cyc(1);
        // R1 reset state
        for (int a = 0; a < 6; a++) rd_chk(a, 8'h00, "R1 reset reg");
        chk(irq_valid == 0, "R1 valid after reset", irq_valid, 0);

        // R2/R3 layout, pad bits, write-1 to flag does not set
        wr(1, 8'hFF);
        rd_chk(1, 8'h37, "R2 R3 readback 0xFF");
        wr(6, 8'hFF);
        rd_chk(6, 8'h00, "R3 addr6 read");
        rd_chk(7, 8'h00, "R3 addr7 read");
        rd_chk(0, 8'h00, "R3 addr6 no alias");
        wr(1, 8'h00);

        // R4 rising edge latency, R7 presentation, R10 sticky
        wr(0, 8'h13);
        pin_in[0] = 1'b1;
        cyc(2); rd_chk(0, 8'h13, "R4 not yet set");
        cyc(1); rd_chk(0, 8'h1B, "R4 set on third edge");
        chk(irq_valid && irq_chan == 0 && irq_level == 3, "R7 present ch0", {irq_valid, irq_chan, irq_level}, 7'b1_000_011);
        pin_in[0] = 1'b0;
        cyc(4); rd_chk(0, 8'h1B, "R10 sticky after pin idle");

        // R7 strict comparison
        cpu_level = 3'd3; #1;
        chk(irq_valid == 0, "R7 equal level blocked", irq_valid, 0);
        cpu_level = 3'd2; #1;
        chk(irq_valid == 1, "R7 higher level passes", irq_valid, 1);
        cpu_level = 3'd0;

        // R3 software clear only
        wr(0, 8'h1B); rd_chk(0, 8'h1B, "R3 write1 keeps flag");
        wr(0, 8'h13); rd_chk(0, 8'h13, "R3 write0 clears flag");

        // R4 falling edge, rising ignored
        wr(2, 8'h05);
        pin_in[2] = 1'b1;
        cyc(4); rd_chk(2, 8'h05, "R4 wrong direction ignored");
        pin_in[2] = 1'b0;
        cyc(2); rd_chk(2, 8'h05, "R4 falling not yet");
        cyc(1); rd_chk(2, 8'h0D, "R4 falling sets");

        // R5 both edges
        both_edge[3] = 1'b1;
        wr(3, 8'h02);
        pin_in[3] = 1'b1;
        cyc(3); rd_chk(3, 8'h0A, "R5 rising sets");
        wr(3, 8'h02); rd_chk(3, 8'h02, "R5 cleared");
        pin_in[3] = 1'b0;
        cyc(3); rd_chk(3, 8'h0A, "R5 falling sets");
        wr(3, 8'h02);
        both_edge[3] = 1'b0;

        // R6 level mode, R8 priority, R9 ack
        wr(1, 8'h37);
        pin_in[1] = 1'b1;
        cyc(3); rd_chk(1, 8'h3F, "R6 level sets");
        chk(irq_chan == 1 && irq_level == 7, "R8 highest wins", irq_chan, 1);
        ack_once();
        rd_chk(1, 8'h37, "R9 ack clears level flag");
        chk(irq_valid && irq_chan == 2, "R8 next winner ch2", irq_chan, 2);
        cyc(1); rd_chk(1, 8'h3F, "R6 re-set while level held");
        pin_in[1] = 1'b0;
        cyc(4);
        wr(1, 8'h30); rd_chk(1, 8'h30, "R6 cleared after level gone");
        ack_once();
        rd_chk(2, 8'h05, "R9 ack clears ch2");
        chk(irq_valid == 0, "R9 nothing pending", irq_valid, 0);

        // R8 tie on equal priority
        wr(4, 8'h16); wr(5, 8'h16);
        pin_in[5:4] = 2'b11;
        cyc(3);
        chk(irq_valid && irq_chan == 4 && irq_level == 6, "R8 tie lowest channel", irq_chan, 4);
        ack_once();
        chk(irq_valid && irq_chan == 5, "R9 R8 ack then ch5", irq_chan, 5);
        ack_once();
        chk(irq_valid == 0, "R9 both acked", irq_valid, 0);

        // R7 priority 0 never presented, R9 ack without valid ignored
        wr(5, 8'h10);
        pin_in[5] = 1'b0; cyc(4);
        pin_in[5] = 1'b1; cyc(3);
        rd_chk(5, 8'h18, "R7 level0 flag recorded");
        chk(irq_valid == 0, "R7 level0 not presented", irq_valid, 0);
        ack_once();
        rd_chk(5, 8'h18, "R9 ack without valid ignored");

        cyc(2);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule